// File: doc/BRIEF.md
# Input Change-of-State Interrupt Logic

This block watches four general-purpose input pins and keeps a change flag for each one. A flag sets only when a new pin level has been seen on two consecutive sample ticks and that level differs from the level the block last accepted. With a tick period of about 25 µs, this filters out glitches and gives an acceptance delay of 25 to 50 µs. A readable change register holds the four flags next to the four live, synchronized pin levels. Reading this register clears the flags.

The flags are ANDed with four enable bits from an auxiliary control register. The four results are ORed into bit 7 of an interrupt status byte. Bits [6:0] of that byte come from other interrupt sources, which enter as plain inputs. The status byte is ANDed with a mask register, and the masked bits are NORed to drive an active-low interrupt request.

The CPU uses a small register interface. The two-bit address map is fixed: 0 is the change register (read-only), 1 is the auxiliary control register, 2 is the interrupt status register (read-only), and 3 is the mask register. Read data is combinational from the address.

Top module: `cos_irq`

## Requirements
- R1: Reading address 0 returns the change flags in bits [7:4] (bit 4 is pin 0) and the pin levels in bits [3:0]. Each pin level comes through a two-flop synchronizer, so it appears two clock edges after the pin changes.
- R2: A change flag sets only on a `tick` edge where the synchronized pin equals the value captured at the previous tick and differs from the last accepted level. A level seen on one tick only, or a pulse that ends before the next tick, sets no flag.
- R3: A read of address 0 (`rd` high at a clock edge) clears all four change flags. A read of address 2 clears nothing.
- R4: If a flag qualifies in the same cycle as a read of address 0, that flag is set after the edge.
- R5: Address 1 is a readable and writable 8-bit register, and all 8 bits are stored. Status bit 7 is the OR over i of (flag i AND aux bit i), for i in [3:0].
- R6: Status bits [6:0] equal `src_status` unchanged, whatever the mask holds.
- R7: `irq_n` is low exactly when (status AND mask) is nonzero. The mask is at address 3 and is readable and writable.
- R8: Reset clears the flags, the synchronizer, the accepted levels, the aux register and the mask, so `irq_n` is high after reset. Writes to addresses 0 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle sample strobe, about every 25 µs |
| pins | input | 4 | Asynchronous general-purpose inputs |
| addr | input | 2 | Register address |
| rd | input | 1 | Read strobe (a read of address 0 clears the flags) |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| src_status | input | 7 | Other interrupt sources, status bits [6:0] |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A pin level reaches `rdata[3:0]` two edges after it changes, so the bench waits three cycles before it reads a level or starts ticking. A flag can set only on the second tick edge after the change. The bench therefore reads the flags at the falling edge after that tick, and once more after only one tick to show that no flag has set yet. Status and `irq_n` follow the registers combinationally, so they are sampled at the falling edge right after the write or tick that changes them. A read clears the flags at the rising edge inside the read, and the next read shows the result.

// File: rtl/cos_irq.sv
module cos_irq #(
  parameter int NPIN = 4,
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NPIN-1:0] pins,
  input  logic [1:0]      addr,
  input  logic            rd,
  input  logic            wr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic [NSRC-1:0] src_status,
  output logic            irq_n
);
  logic [NPIN-1:0] meta, live, samp, acc, flags, qual;
  logic [7:0]      aux, mask, status;
  logic            clr;

  assign qual   = tick ? (live ~^ samp) & (live ^ acc) : '0;
  assign clr    = rd && addr == 2'd0;
  assign status = {|(flags & aux[NPIN-1:0]), src_status};
  assign irq_n  = ~|(status & mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= '0; live <= '0; samp <= '0; acc <= '0; flags <= '0;
    end else begin
      meta  <= pins;
      live  <= meta;
      if (tick) samp <= live;
      acc   <= (acc & ~qual) | (live & qual);
      flags <= (clr ? '0 : flags) | qual;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      aux <= '0; mask <= '0;
    end else if (wr) begin
      if (addr == 2'd1) aux  <= wdata;
      if (addr == 2'd3) mask <= wdata;
    end

  always_comb
    case (addr)
      2'd0:    rdata = {flags, live};
      2'd1:    rdata = aux;
      2'd2:    rdata = status;
      default: rdata = mask;
    endcase

  // R2: flags only rise on a tick edge
  a_r2_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((flags & ~$past(flags)) == '0));
  // R3: a change-register read with no tick empties the flags
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 2'd0 && !tick) |=> flags == '0);
  // R3: a status read leaves the flags alone
  a_r3_status_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 2'd2 && !tick) |=> flags == $past(flags));
  // R4: a qualified event is never dropped
  a_r4_no_lost_event: assert property (@(posedge clk) disable iff (!rst_n)
    (|qual) |=> ((flags & $past(qual)) == $past(qual)));
  // R7: a request needs a mask bit
  a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> mask != 8'h00);
endmodule

// File: tb/cos_irq_tb_top.sv
module cos_irq_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, rd = 0, wr = 0;
  logic [3:0] pins = '0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, d;
  logic [6:0] src = '0;
  logic irq_n;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  cos_irq dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .pins(pins), .addr(addr),
    .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .src_status(src), .irq_n(irq_n));

  // row: [15:8] mask, [7:1] src_status, [0] expected irq_n (aux and flags zero)
  localparam logic [15:0] VEC [8] = '{
    {8'h00, 7'h7F, 1'b1}, {8'h01, 7'h01, 1'b0}, {8'h01, 7'h02, 1'b1},
    {8'h40, 7'h40, 1'b0}, {8'h3E, 7'h41, 1'b1}, {8'h80, 7'h7F, 1'b1},
    {8'hFF, 7'h00, 1'b1}, {8'hFF, 7'h10, 1'b0}};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1; #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    check("R8 irq_n after reset", {7'd0, irq_n}, 8'h01);
    rd_reg(2'd0, d); check("R8 change reg", d, 8'h00);
    rd_reg(2'd1, d); check("R8 aux", d, 8'h00);
    rd_reg(2'd3, d); check("R8 mask", d, 8'h00);

    foreach (VEC[i]) begin
      src = VEC[i][7:1];
      wr_reg(2'd3, VEC[i][15:8]);
      check("R7 vector irq_n", {7'd0, irq_n}, {7'd0, VEC[i][0]});
      rd_reg(2'd2, d); check("R6 status pass-through", d, {1'b0, VEC[i][7:1]});
    end
    src = '0; wr_reg(2'd3, 8'h00);

    pins = 4'b0101; cyc(3);
    rd_reg(2'd0, d); check("R1 live levels, no tick", d, 8'h05);
    pulse;
    rd_reg(2'd0, d); check("R2 one tick not enough", d, 8'h05);
    pulse;
    rd_reg(2'd2, d); check("R5 bit7 off with aux=0", d, 8'h00);
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd2, d); check("R5 bit7 with aux bit0", d, 8'h80);
    rd_reg(2'd2, d); check("R3 status read keeps", d, 8'h80);
    rd_reg(2'd0, d); check("R1 flags and levels", d, 8'h55);
    rd_reg(2'd0, d); check("R3 read clears flags", d, 8'h05);

    wr_reg(2'd3, 8'h80);
    check("R7 irq_n idle", {7'd0, irq_n}, 8'h01);
    pins = 4'b0100; cyc(3); pulse; pulse;
    check("R7 irq_n from change", {7'd0, irq_n}, 8'h00);
    wr_reg(2'd1, 8'h02);
    check("R5 disabled pin no irq", {7'd0, irq_n}, 8'h01);
    wr_reg(2'd1, 8'hF1);
    rd_reg(2'd1, d); check("R5 aux readback", d, 8'hF1);

    pins = 4'b0110; cyc(3); pulse;
    pins = 4'b0100; cyc(3); pulse; pulse;
    rd_reg(2'd0, d); check("R2 glitch rejected", d, 8'h14);

    pins = 4'b0000; cyc(3); pulse;
    @(negedge clk); tick = 1; addr = 2'd0; rd = 1;
    @(negedge clk); tick = 0; rd = 0;
    rd_reg(2'd0, d); check("R4 event kept on read", d, 8'h40);

    wr_reg(2'd0, 8'hFF); wr_reg(2'd2, 8'hFF);
    rd_reg(2'd0, d); check("R8 write to addr0 ignored", d, 8'h00);

    wr_reg(2'd3, 8'hFF); src = 7'h01; cyc(1);
    check("R7 irq_n active", {7'd0, irq_n}, 8'h00);
    src = '0; rst_n = 0; cyc(1);
    check("R8 irq_n in reset", {7'd0, irq_n}, 8'h01);
    rst_n = 1;
    rd_reg(2'd3, d); check("R8 mask cleared", d, 8'h00);
    rd_reg(2'd1, d); check("R8 aux cleared", d, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule